// File: doc/BRIEF.md
# External Interrupt and Event Line Controller

The block watches nineteen request lines and turns their transitions into interrupt requests and wake-up pulses. Lines 0 to 15 are meant for I/O pins. Lines 16, 17 and 18 take internal sources: a supply-voltage monitor, an alarm and a bus wake-up. Each raw line first passes through a two-flop synchronizer. An edge classifier then compares the newest synchronized sample with the one before it. Each line can be set to respond to rising edges, falling edges, both, or neither.

A detected edge, or a software trigger, latches the line's pending bit. That bit holds until software writes 1 to clear it. The block drives a level interrupt request for each line whose pending bit is set and whose interrupt enable is set. Independently, an edge or software trigger on any line whose event enable is set produces a one-clock wake-up pulse. The pulse alone never raises an interrupt request. Software reaches six word registers over a simple synchronous bus. Writes take effect on the clock edge. Reads are combinational on the address.

Top module: `ext_irq_ctrl`

## Requirements
- R1: After synchronous reset, every register reads 0 and both `irq_req` and `evt_pulse` are low. Every line is therefore disabled for interrupts and events and detects no edges.
- R2: Suppose a line has its rising select set and `line_in` goes 0→1 before clock edge k. The pending bit is set at edge k+2, so `irq_req` rises after edge k+2 when the line's interrupt enable is 1. It is still low after edge k+1.
- R3: A line with its falling select set latches pending on a 1→0 transition, with the same latency as R2.
- R4: A line with both selects set latches pending on either transition.
- R5: Pending register (address 5, bit n = line n): writing 1 clears a bit and writing 0 leaves it unchanged. If a selected edge or software trigger arrives in the same cycle as the clear, the bit stays set.
- R6: `irq_req[n]` equals pending bit n ANDed with interrupt enable bit n. Changing the enable masks or unmasks the request without altering pending.
- R7: Writing 1 to bit n of the software trigger register (address 4) sets that bit. The same write sets pending n on the next edge only if interrupt enable n is 1. Writing 0 has no effect. The trigger bit returns to 0 when pending n is cleared through address 5.
- R8: `evt_pulse` is high for exactly the one cycle after a clock edge at which an edge (R2 to R4) or a software trigger occurred on a line whose event enable is 1. With interrupt enable 0, such an event leaves `irq_req` low.
- R9: The register map uses word addresses. 0 is interrupt enable, 1 is event enable, 2 is rising select and 3 is falling select; these are read/write, with bit n = line n. 4 is the software trigger register and 5 is pending. Addresses 6 and 7 read 0. Bits above 18 read 0.
- R10: A line with neither select set never sets its pending bit, whatever its input does.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| line_in | input | 19 | Raw asynchronous request lines |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 3 | Register word address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr` |
| irq_req | output | 19 | Per-line level interrupt request |
| evt_pulse | output | 1 | One-cycle wake-up event pulse |

## Verification
Assertions check these properties on every cycle:
- A clear without a same-cycle set empties a pending bit.
- A pending bit never drops unless it was cleared.
- Every detected edge lands in pending.
- The software trigger bit is gone after its pending bit is cleared.
- Each event pulse has a masked cause one cycle earlier.
- The state after reset is as R1 states.

Only the bench's scenarios can show the following: the exact two-stage synchronizer latency from a raw transition, the choice of edge polarity, that unselected lines are ignored, and the register readback map. A behavioural reference model, compared every clock, also covers the clear-versus-edge collision and the event-only case that keeps `irq_req` low.

// File: rtl/ext_irq_pkg.sv
package ext_irq_pkg;

    localparam int ADDR_W = 3;

    typedef enum logic [ADDR_W-1:0] {
        REG_IRQ_EN   = 3'd0,
        REG_EVT_EN   = 3'd1,
        REG_RISE_SEL = 3'd2,
        REG_FALL_SEL = 3'd3,
        REG_SW_TRIG  = 3'd4,
        REG_PENDING  = 3'd5
    } reg_sel_e;

    // True when a write strobe targets the given register
    function automatic logic hits(input logic wr, input logic [ADDR_W-1:0] addr,
                                  input reg_sel_e sel);
        return wr && (addr == sel);
    endfunction

endpackage

// File: rtl/line_sync.sv
module line_sync #(
    parameter int N = 19
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [N-1:0] raw_in,
    input  logic [N-1:0] rise_sel,
    input  logic [N-1:0] fall_sel,
    output logic [N-1:0] edge_hit
);
    logic [N-1:0] meta_q;
    logic [N-1:0] sync_q;
    logic [N-1:0] prev_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            meta_q <= '0;
            sync_q <= '0;
            prev_q <= '0;
        end else begin
            meta_q <= raw_in;
            sync_q <= meta_q;
            prev_q <= sync_q;
        end
    end

    for (genvar i = 0; i < N; i++) begin : g_line
        logic went_up;
        logic went_down;
        assign went_up     = sync_q[i] & ~prev_q[i];
        assign went_down   = ~sync_q[i] & prev_q[i];
        assign edge_hit[i] = (went_up & rise_sel[i]) | (went_down & fall_sel[i]);
    end

endmodule

// File: rtl/cfg_regs.sv
module cfg_regs
    import ext_irq_pkg::*;
#(
    parameter int N  = 19,
    parameter int DW = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DW-1:0]     wdata,
    input  logic [N-1:0]      pend,
    output logic [N-1:0]      irq_en,
    output logic [N-1:0]      evt_en,
    output logic [N-1:0]      rise_sel,
    output logic [N-1:0]      fall_sel,
    output logic [N-1:0]      sw_set,
    output logic [N-1:0]      pend_clr,
    output logic [DW-1:0]     rdata
);
    logic [N-1:0] sw_q;
    logic [N-1:0] wbits;

    assign wbits    = wdata[N-1:0];
    assign sw_set   = hits(wr_en, addr, REG_SW_TRIG) ? wbits : '0;
    assign pend_clr = hits(wr_en, addr, REG_PENDING) ? wbits : '0;

    if (DW > N) begin : g_spare
        logic unused_hi;
        assign unused_hi = ^wdata[DW-1:N];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            irq_en   <= '0;
            evt_en   <= '0;
            rise_sel <= '0;
            fall_sel <= '0;
            sw_q     <= '0;
        end else begin
            if (hits(wr_en, addr, REG_IRQ_EN))   irq_en   <= wbits;
            if (hits(wr_en, addr, REG_EVT_EN))   evt_en   <= wbits;
            if (hits(wr_en, addr, REG_RISE_SEL)) rise_sel <= wbits;
            if (hits(wr_en, addr, REG_FALL_SEL)) fall_sel <= wbits;
            sw_q <= (sw_q & ~pend_clr) | sw_set;
        end
    end

    always_comb begin
        rdata = '0;
        case (addr)
            REG_IRQ_EN:   rdata[N-1:0] = irq_en;
            REG_EVT_EN:   rdata[N-1:0] = evt_en;
            REG_RISE_SEL: rdata[N-1:0] = rise_sel;
            REG_FALL_SEL: rdata[N-1:0] = fall_sel;
            REG_SW_TRIG:  rdata[N-1:0] = sw_q;
            REG_PENDING:  rdata[N-1:0] = pend;
            default:      rdata        = '0;
        endcase
    end

    // R7: a trigger bit is gone once its pending bit was cleared
    a_r7_sw_self_clear: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> ((sw_q & $past(pend_clr)) == '0));

    // R1: configuration is empty right after reset
    a_r1_cfg_reset: assert property (@(posedge clk)
        $past(rst) |-> (irq_en == '0 && evt_en == '0 && rise_sel == '0
                        && fall_sel == '0 && sw_q == '0));

endmodule

// File: rtl/pend_unit.sv
module pend_unit #(
    parameter int N = 19
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [N-1:0] edge_hit,
    input  logic [N-1:0] sw_set,
    input  logic [N-1:0] pend_clr,
    input  logic [N-1:0] irq_en,
    input  logic [N-1:0] evt_en,
    output logic [N-1:0] pend,
    output logic [N-1:0] irq_req,
    output logic         evt_pulse
);
    logic [N-1:0] set_now;
    logic [N-1:0] trig_now;

    assign trig_now = edge_hit | sw_set;
    assign set_now  = edge_hit | (sw_set & irq_en);

    always_ff @(posedge clk) begin
        if (rst) begin
            pend      <= '0;
            evt_pulse <= 1'b0;
        end else begin
            pend      <= (pend & ~pend_clr) | set_now;
            evt_pulse <= |(trig_now & evt_en);
        end
    end

    assign irq_req = pend & irq_en;

    // R5: a clear without a concurrent set empties the bit
    a_r5_clear_takes: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> ((pend & $past(pend_clr & ~set_now)) == '0));

    // R5: pending bits are sticky until cleared
    a_r5_sticky: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> (($past(pend & ~pend_clr) & ~pend) == '0));

    // R2: every detected edge lands in pending
    a_r2_edge_latched: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> ((pend & $past(edge_hit)) == $past(edge_hit)));

    // R8: an event pulse always has an enabled cause one cycle earlier
    a_r8_evt_cause: assert property (@(posedge clk) disable iff (rst)
        evt_pulse |-> $past(|(trig_now & evt_en)));

    // R1: nothing pending and no pulse right after reset
    a_r1_pend_reset: assert property (@(posedge clk)
        $past(rst) |-> (pend == '0 && !evt_pulse));

endmodule

// File: rtl/ext_irq_ctrl.sv
module ext_irq_ctrl
    import ext_irq_pkg::*;
#(
    parameter int N  = 19,
    parameter int DW = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [N-1:0]      line_in,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DW-1:0]     bus_wdata,
    output logic [DW-1:0]     bus_rdata,
    output logic [N-1:0]      irq_req,
    output logic              evt_pulse
);
    logic [N-1:0] irq_en, evt_en, rise_sel, fall_sel;
    logic [N-1:0] sw_set, pend_clr, pend, edge_hit;

    line_sync #(.N(N)) u_sync (
        .clk(clk), .rst(rst), .raw_in(line_in),
        .rise_sel(rise_sel), .fall_sel(fall_sel), .edge_hit(edge_hit)
    );

    cfg_regs #(.N(N), .DW(DW)) u_regs (
        .clk(clk), .rst(rst), .wr_en(bus_wr), .addr(bus_addr), .wdata(bus_wdata),
        .pend(pend), .irq_en(irq_en), .evt_en(evt_en), .rise_sel(rise_sel),
        .fall_sel(fall_sel), .sw_set(sw_set), .pend_clr(pend_clr), .rdata(bus_rdata)
    );

    pend_unit #(.N(N)) u_pend (
        .clk(clk), .rst(rst), .edge_hit(edge_hit), .sw_set(sw_set),
        .pend_clr(pend_clr), .irq_en(irq_en), .evt_en(evt_en),
        .pend(pend), .irq_req(irq_req), .evt_pulse(evt_pulse)
    );

    // R6: a request never appears for a disabled line
    a_r6_req_gated: assert property (@(posedge clk) disable iff (rst)
        (irq_req & ~irq_en) == '0);

endmodule

// File: tb/ext_irq_ctrl_bench.sv
`timescale 1ns/1ps
module ext_irq_ctrl_bench;
    localparam int N  = 19;
    localparam int DW = 32;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [N-1:0]  line_in = '0;
    logic          bus_wr = 1'b0;
    logic [2:0]    bus_addr = '0;
    logic [DW-1:0] bus_wdata = '0;
    logic [DW-1:0] bus_rdata;
    logic [N-1:0]  irq_req;
    logic          evt_pulse;

    int tests = 0;
    int fails = 0;
    int evt_count = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    ext_irq_ctrl #(.N(N), .DW(DW)) u_ext_irq_ctrl (
        .clk(clk), .rst(rst), .line_in(line_in), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .irq_req(irq_req), .evt_pulse(evt_pulse)
    );

    // Behavioural reference: raw history kept in a queue, registers as integers
    logic [N-1:0] hist[$];
    int m_ien, m_een, m_rise, m_fall, m_sw, m_pend;
    bit m_evt;

    task automatic check(input string req, input longint act, input longint exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    always @(posedge clk) begin
        int newer, older, edges, swb, clr, mask;
        mask = (1 << N) - 1;
        if (rst) begin
            hist = '{'0, '0, '0};
            m_ien = 0; m_een = 0; m_rise = 0; m_fall = 0; m_sw = 0; m_pend = 0;
            m_evt = 0;
        end else begin
            newer = int'(hist[1]);
            older = int'(hist[2]);
            edges = ((newer & ~older & m_rise) | (~newer & older & m_fall)) & mask;
            swb = (bus_wr && bus_addr == 3'd4) ? int'(bus_wdata) & mask : 0;
            clr = (bus_wr && bus_addr == 3'd5) ? int'(bus_wdata) & mask : 0;
            m_evt  = ((edges | swb) & m_een) != 0;
            m_pend = (m_pend & ~clr) | edges | (swb & m_ien);
            m_sw   = (m_sw & ~clr) | swb;
            if (bus_wr && bus_addr == 3'd0) m_ien  = int'(bus_wdata) & mask;
            if (bus_wr && bus_addr == 3'd1) m_een  = int'(bus_wdata) & mask;
            if (bus_wr && bus_addr == 3'd2) m_rise = int'(bus_wdata) & mask;
            if (bus_wr && bus_addr == 3'd3) m_fall = int'(bus_wdata) & mask;
            void'(hist.pop_back());
            hist.push_front(line_in);
        end
        #1;
        if (!rst) begin
            check("R6 irq_req vs model", irq_req, m_pend & m_ien);
            check("R8 evt_pulse vs model", evt_pulse, m_evt);
        end
        if (evt_pulse) evt_count++;
    end

    task automatic wr(input logic [2:0] a, input int d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, input int exp, input string req);
        @(negedge clk);
        bus_addr = a;
        #0.5;
        check(req, bus_rdata, exp);
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        #1000000;
        if (!done) begin
            fails++; tests++;
            $display("FAIL watchdog expired");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R1: reset state
        check("R1 irq_req after reset", irq_req, 0);
        check("R1 evt_pulse after reset", evt_pulse, 0);
        for (int a = 0; a < 8; a++) rd(3'(a), 0, "R1 register reset value");

        // R9: readback map, upper bits read 0
        wr(3'd0, 32'hFFFF_FFFF);
        wr(3'd1, 32'h0005_0000);
        wr(3'd2, 32'h0000_1234);
        wr(3'd3, 32'h0004_8000);
        rd(3'd0, 32'h0007_FFFF, "R9 interrupt enable readback");
        rd(3'd1, 32'h0005_0000, "R9 event enable readback");
        rd(3'd2, 32'h0000_1234, "R9 rising select readback");
        rd(3'd3, 32'h0004_8000, "R9 falling select readback");
        rd(3'd6, 0, "R9 unmapped address 6");
        rd(3'd7, 0, "R9 unmapped address 7");
        wr(3'd1, 0);
        wr(3'd2, 32'h0000_0008);           // line 3 rising
        wr(3'd3, 32'h0000_0020);           // line 5 falling

        // R2: rising edge latency on line 3
        @(negedge clk);
        line_in[3] = 1'b1;
        @(posedge clk); @(posedge clk); #1;
        check("R2 irq[3] low after second edge", irq_req[3], 0);
        @(posedge clk); #1;
        check("R2 irq[3] high after third edge", irq_req[3], 1);
        rd(3'd5, 32'h8, "R2 pending bit 3");

        // R5: write 0 keeps, write 1 clears
        wr(3'd5, 0);
        rd(3'd5, 32'h8, "R5 write 0 leaves pending");
        wr(3'd5, 32'h8);
        rd(3'd5, 0, "R5 write 1 clears pending");
        @(negedge clk); line_in[3] = 1'b0;
        idle(4);
        rd(3'd5, 0, "R2 falling edge ignored on rising-only line");

        // R3: falling edge on line 5
        @(negedge clk); line_in[5] = 1'b1;
        idle(4);
        rd(3'd5, 0, "R3 rising edge ignored on falling-only line");
        @(negedge clk); line_in[5] = 1'b0;
        idle(4);
        rd(3'd5, 32'h20, "R3 falling edge latched");
        wr(3'd5, 32'h20);

        // R4: both edges on line 17
        wr(3'd2, 32'h0002_0008);
        wr(3'd3, 32'h0002_0028);
        @(negedge clk); line_in[17] = 1'b1;
        idle(4);
        rd(3'd5, 32'h0002_0000, "R4 rising side");
        wr(3'd5, 32'h0002_0000);
        @(negedge clk); line_in[17] = 1'b0;
        idle(4);
        rd(3'd5, 32'h0002_0000, "R4 falling side");

        // R5: clear collides with a new edge: bit stays set
        @(negedge clk); line_in[17] = 1'b1;
        @(negedge clk); @(negedge clk);
        bus_wr = 1'b1; bus_addr = 3'd5; bus_wdata = 32'h0002_0000;
        @(negedge clk); bus_wr = 1'b0;
        rd(3'd5, 32'h0002_0000, "R5 set wins over clear");
        wr(3'd5, 32'h0002_0000);

        // R6: masking hides the request, pending untouched
        @(negedge clk); line_in[3] = 1'b1;
        idle(4);
        wr(3'd0, 32'h0000_0000);
        #0.5 check("R6 irq masked", irq_req, 0);
        rd(3'd5, 32'h8, "R6 pending kept while masked");
        wr(3'd0, 32'h0007_FFFF);
        #0.5 check("R6 irq unmasked", irq_req, 32'h8);
        wr(3'd5, 32'h8);

        // R10: unselected line ignores activity
        for (int k = 0; k < 3; k++) begin
            @(negedge clk); line_in[9] = ~line_in[9];
            idle(3);
        end
        rd(3'd5, 0, "R10 unselected line stays clear");

        // R7: software trigger with and without interrupt enable
        wr(3'd0, 32'h0000_0400);
        wr(3'd4, 32'h0000_0C00);
        rd(3'd4, 32'h0000_0C00, "R7 trigger bits set");
        rd(3'd5, 32'h0000_0400, "R7 pending only for enabled line");
        #0.5 check("R7 irq for line 10", irq_req, 32'h400);
        wr(3'd4, 0);
        rd(3'd4, 32'h0000_0C00, "R7 write 0 no effect");
        wr(3'd5, 32'h0000_0400);
        rd(3'd4, 32'h0000_0800, "R7 trigger bit cleared with pending");

        // R8: event only on line 12, no interrupt
        wr(3'd0, 0);
        wr(3'd1, 32'h0000_1000);
        wr(3'd2, 32'h0000_1000);
        evt_count = 0;
        @(negedge clk); line_in[12] = 1'b1;
        idle(6);
        check("R8 exactly one event pulse", evt_count, 1);
        check("R8 no interrupt from event", irq_req, 0);
        evt_count = 0;
        wr(3'd4, 32'h0000_1000);
        idle(2);
        check("R8 software trigger pulse", evt_count, 1);

        idle(3);
        done = 1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule